// File: doc/BRIEF.md
# Flash Command Sequencer

This block sits on the host side of a parallel NOR flash that shares one 16-bit address/data bus. It takes one request at a time for a program, a sector erase or a whole-chip erase, and turns it into the unlock and command write cycles the flash expects. The address phase of each cycle is marked by the address-valid strobe. After the last write it releases the bus and reads status at the target address, again and again, until a status bit stops toggling or a poll limit runs out.

The host presents the operation, a 22-bit target address and 16 bits of program data on a valid/ready handshake. Write-strobe low and high widths and the poll limit come from configuration inputs, counted in clock cycles. The block ends every accepted request with exactly one single-cycle pulse, either done or error, and is then ready for the next request.

Top module: `nor_flash_seq`

## Requirements
- R1: After a synchronous reset, and whenever no request is being served, req_ready is 1, every flash strobe (ce_n, we_n, oe_n, avd_n) is 1 and fl_adq_oe is 0. req_ready drops in the cycle after a request is accepted and stays low until the operation ends.
- R2: Operation code 2'b00 (program) issues four writes in this order: 0x0AA to 0x555, 0x055 to 0x2AA, 0x0A0 to 0x555, then the request data to the full request address. Address bits 21:16 are 0 in the first three writes.
- R3: Operation code 2'b01 (sector erase) issues six writes: 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, then 0x30 to the full request address.
- R4: Operation code 2'b10 (chip erase) issues the same six writes as R3, except that the last one is 0x10 to 0x555. Its upper address bits are 0 in every write. Code 2'b11 behaves as a program.
- R5: Each write has a one-cycle address phase with avd_n low, then we_n low for max(cfg_wr_low,1) cycles, then we_n high for max(cfg_wr_high,1) cycles. The block drives the bus in all three phases and keeps ce_n low throughout.
- R6: fl_adq_oe is 0 in every cycle where oe_n is low, and also in the cycle just before oe_n falls.
- R7: Each status read latches the request address with avd_n low, waits one cycle with the bus released, then holds oe_n low for 2 cycles. Reads repeat until two consecutive reads agree on data bit 6. Done pulses after B+2 reads when the flash toggles bit 6 on its first B comparisons.
- R8: If the number of comparisons that showed a toggle reaches max(cfg_poll_limit,1), the error pulse fires and the block returns to idle.
- R9: Each accepted request produces exactly one one-cycle pulse on op_done or op_error, never both, and req_ready is high in that cycle. A request held valid while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| req_op | input | 2 | Operation code (R2 to R4) |
| req_addr | input | 22 | Program, sector or status address |
| req_data | input | 16 | Program data |
| cfg_wr_low | input | 8 | Write-strobe low width in cycles |
| cfg_wr_high | input | 8 | Write-strobe high width in cycles |
| cfg_poll_limit | input | 16 | Maximum toggling status comparisons |
| op_done | output | 1 | Operation finished pulse |
| op_error | output | 1 | Poll limit reached pulse |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write strobe, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_avd_n | output | 1 | Address valid strobe, active low |
| fl_addr_hi | output | 6 | Address bits 21:16 |
| fl_adq_o | output | 16 | Shared bus, outbound value |
| fl_adq_oe | output | 1 | Shared bus drive enable |
| fl_adq_i | input | 16 | Shared bus, inbound value |

## Verification
The hardest condition to reach is the boundary between a late finish and a timeout: the flash stops toggling on exactly the comparison that would have hit the poll limit, or the limit is zero. The bench models a flash whose bit 6 flips on a chosen number of reads and then holds. It picks toggle counts just below, at and above the limit, so both outcomes are seen with exact read counts. A second request held valid through a busy operation shows that nothing extra reaches the bus.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    localparam int DW   = 16;
    localparam int IDXW = 3;

    typedef enum logic [1:0] {
        OP_PROG   = 2'b00,
        OP_SERASE = 2'b01,
        OP_CERASE = 2'b10,
        OP_RSVD   = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WADDR,
        ST_WLOW,
        ST_WHIGH,
        ST_TURN,
        ST_RADDR,
        ST_RGAP,
        ST_ROE
    } st_e;

    // one bus write of a command sequence
    typedef struct packed {
        logic [DW-1:0] lo_addr;
        logic [DW-1:0] data;
        logic          use_tgt_addr;
        logic          use_req_data;
    } cyc_t;

    localparam logic [DW-1:0] KEY_ADDR_A = 16'h0555;
    localparam logic [DW-1:0] KEY_ADDR_B = 16'h02AA;
    localparam logic [DW-1:0] KEY_DAT_A  = 16'h00AA;
    localparam logic [DW-1:0] KEY_DAT_B  = 16'h0055;
    localparam logic [DW-1:0] CMD_WRITE  = 16'h00A0;
    localparam logic [DW-1:0] CMD_ERASE  = 16'h0080;
    localparam logic [DW-1:0] CMD_SECTOR = 16'h0030;
    localparam logic [DW-1:0] CMD_WHOLE  = 16'h0010;

    function automatic logic is_erase(op_e op);
        return (op == OP_SERASE) || (op == OP_CERASE);
    endfunction

    function automatic logic [IDXW-1:0] seq_last(op_e op);
        return is_erase(op) ? IDXW'(5) : IDXW'(3);
    endfunction

    function automatic cyc_t seq_cycle(op_e op, logic [IDXW-1:0] idx);
        cyc_t c;
        c = '{lo_addr: KEY_ADDR_A, data: KEY_DAT_A, use_tgt_addr: 1'b0, use_req_data: 1'b0};
        case (idx)
            3'd1: begin
                c.lo_addr = KEY_ADDR_B;
                c.data    = KEY_DAT_B;
            end
            3'd2: c.data = is_erase(op) ? CMD_ERASE : CMD_WRITE;
            3'd3: begin
                if (!is_erase(op)) begin
                    c.use_tgt_addr = 1'b1;
                    c.use_req_data = 1'b1;
                end
            end
            3'd4: begin
                c.lo_addr = KEY_ADDR_B;
                c.data    = KEY_DAT_B;
            end
            3'd5: begin
                if (op == OP_CERASE) begin
                    c.data = CMD_WHOLE;
                end else begin
                    c.use_tgt_addr = 1'b1;
                    c.data         = CMD_SECTOR;
                end
            end
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/nor_seq_rom.sv
module nor_seq_rom
    import nor_seq_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  op_e                 op,
    input  logic [IDXW-1:0]     idx,
    input  logic [ADDR_W-1:0]   tgt_addr,
    input  logic [DW-1:0]       tgt_data,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [DW-1:0]       bus_data,
    output logic                is_last
);
    localparam int HIW = ADDR_W - DW;

    cyc_t cyc;

    always_comb begin
        cyc      = seq_cycle(op, idx);
        bus_addr = cyc.use_tgt_addr ? tgt_addr : {{HIW{1'b0}}, cyc.lo_addr};
        bus_data = cyc.use_req_data ? tgt_data : cyc.data;
        is_last  = (idx == seq_last(op));
    end
endmodule

// File: rtl/nor_pulse_timer.sv
module nor_pulse_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= TW'(1);
        end else if (load) begin
            cnt <= (load_val == '0) ? TW'(1) : load_val;
        end else if (cnt > TW'(1)) begin
            cnt <= cnt - TW'(1);
        end
    end

    assign expired = (cnt == TW'(1));
endmodule

// File: rtl/nor_toggle_chk.sv
module nor_toggle_chk #(
    parameter int          DW   = 16,
    parameter int          PW   = 16,
    parameter logic [15:0] MASK = 16'h0040
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          sample,
    input  logic [DW-1:0] status,
    input  logic [PW-1:0] limit,
    output logic          settled,
    output logic          timed_out
);
    logic [DW-1:0] prev;
    logic          have_prev;
    logic [PW-1:0] tog_cnt;
    logic          toggled;
    logic [PW:0]   next_cnt;
    logic [PW:0]   lim_eff;

    always_comb begin
        toggled   = ((status ^ prev) & DW'(MASK)) != '0;
        next_cnt  = {1'b0, tog_cnt} + (PW+1)'(1);
        lim_eff   = (limit == '0) ? (PW+1)'(1) : {1'b0, limit};
        settled   = sample && have_prev && !toggled;
        timed_out = sample && have_prev && toggled && (next_cnt >= lim_eff);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            prev      <= '0;
            have_prev <= 1'b0;
            tog_cnt   <= '0;
        end else if (sample) begin
            prev      <= status;
            have_prev <= 1'b1;
            if (have_prev && toggled) begin
                tog_cnt <= next_cnt[PW-1:0];
            end
        end
    end
endmodule

// File: rtl/nor_flash_seq.sv
module nor_flash_seq
    import nor_seq_pkg::*;
#(
    parameter int ADDR_W   = 22,
    parameter int TW       = 8,
    parameter int PW       = 16,
    parameter int RD_WAIT  = 2,
    parameter int STAT_BIT = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [1:0]           req_op,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DW-1:0]        req_data,
    input  logic [TW-1:0]        cfg_wr_low,
    input  logic [TW-1:0]        cfg_wr_high,
    input  logic [PW-1:0]        cfg_poll_limit,
    output logic                 op_done,
    output logic                 op_error,
    output logic                 fl_ce_n,
    output logic                 fl_we_n,
    output logic                 fl_oe_n,
    output logic                 fl_avd_n,
    output logic [ADDR_W-DW-1:0] fl_addr_hi,
    output logic [DW-1:0]        fl_adq_o,
    output logic                 fl_adq_oe,
    input  logic [DW-1:0]        fl_adq_i
);
    localparam logic [TW-1:0] RD_WAIT_T = TW'(RD_WAIT);
    localparam logic [15:0]   STAT_MASK = 16'(1) << STAT_BIT;

    st_e               st, st_n;
    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DW-1:0]     data_q;
    logic [IDXW-1:0]   idx;

    logic [ADDR_W-1:0] cyc_addr;
    logic [DW-1:0]     cyc_data;
    logic              cyc_last;

    logic              tmr_load;
    logic [TW-1:0]     tmr_val;
    logic              tmr_exp;
    logic              idx_inc;
    logic              accept;
    logic              chk_clear;
    logic              chk_sample;
    logic              chk_settled;
    logic              chk_timeout;

    nor_seq_rom #(.ADDR_W(ADDR_W)) u_rom (
        .op       (op_q),
        .idx      (idx),
        .tgt_addr (addr_q),
        .tgt_data (data_q),
        .bus_addr (cyc_addr),
        .bus_data (cyc_data),
        .is_last  (cyc_last)
    );

    nor_pulse_timer #(.TW(TW)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    nor_toggle_chk #(.DW(DW), .PW(PW), .MASK(STAT_MASK)) u_chk (
        .clk       (clk),
        .rst       (rst),
        .clear     (chk_clear),
        .sample    (chk_sample),
        .status    (fl_adq_i),
        .limit     (cfg_poll_limit),
        .settled   (chk_settled),
        .timed_out (chk_timeout)
    );

    // next-state and control strobes
    always_comb begin
        st_n       = st;
        tmr_load   = 1'b0;
        tmr_val    = cfg_wr_low;
        idx_inc    = 1'b0;
        accept     = 1'b0;
        chk_clear  = 1'b0;
        chk_sample = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (req_valid) begin
                    accept    = 1'b1;
                    chk_clear = 1'b1;
                    st_n      = ST_WADDR;
                end
            end
            ST_WADDR: begin
                tmr_load = 1'b1;
                tmr_val  = cfg_wr_low;
                st_n     = ST_WLOW;
            end
            ST_WLOW: begin
                if (tmr_exp) begin
                    tmr_load = 1'b1;
                    tmr_val  = cfg_wr_high;
                    st_n     = ST_WHIGH;
                end
            end
            ST_WHIGH: begin
                if (tmr_exp) begin
                    if (cyc_last) begin
                        st_n = ST_TURN;
                    end else begin
                        idx_inc = 1'b1;
                        st_n    = ST_WADDR;
                    end
                end
            end
            ST_TURN:  st_n = ST_RADDR;
            ST_RADDR: st_n = ST_RGAP;
            ST_RGAP: begin
                tmr_load = 1'b1;
                tmr_val  = RD_WAIT_T;
                st_n     = ST_ROE;
            end
            ST_ROE: begin
                if (tmr_exp) begin
                    chk_sample = 1'b1;
                    st_n = (chk_settled || chk_timeout) ? ST_IDLE : ST_RADDR;
                end
            end
            default: st_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            op_q     <= OP_PROG;
            addr_q   <= '0;
            data_q   <= '0;
            idx      <= '0;
            op_done  <= 1'b0;
            op_error <= 1'b0;
        end else begin
            st       <= st_n;
            op_done  <= chk_sample && chk_settled;
            op_error <= chk_sample && chk_timeout;
            if (accept) begin
                op_q   <= op_e'(req_op);
                addr_q <= req_addr;
                data_q <= req_data;
                idx    <= '0;
            end else if (idx_inc) begin
                idx <= idx + IDXW'(1);
            end
        end
    end

    // bus drive, decoded from state
    always_comb begin
        req_ready  = (st == ST_IDLE);
        fl_ce_n    = 1'b1;
        fl_we_n    = 1'b1;
        fl_oe_n    = 1'b1;
        fl_avd_n   = 1'b1;
        fl_adq_oe  = 1'b0;
        fl_adq_o   = '0;
        fl_addr_hi = '0;
        unique case (st)
            ST_WADDR: begin
                fl_ce_n    = 1'b0;
                fl_avd_n   = 1'b0;
                fl_adq_oe  = 1'b1;
                fl_adq_o   = cyc_addr[DW-1:0];
                fl_addr_hi = cyc_addr[ADDR_W-1:DW];
            end
            ST_WLOW: begin
                fl_ce_n    = 1'b0;
                fl_we_n    = 1'b0;
                fl_adq_oe  = 1'b1;
                fl_adq_o   = cyc_data;
                fl_addr_hi = cyc_addr[ADDR_W-1:DW];
            end
            ST_WHIGH: begin
                fl_ce_n    = 1'b0;
                fl_adq_oe  = 1'b1;
                fl_adq_o   = cyc_data;
                fl_addr_hi = cyc_addr[ADDR_W-1:DW];
            end
            ST_RADDR: begin
                fl_ce_n    = 1'b0;
                fl_avd_n   = 1'b0;
                fl_adq_oe  = 1'b1;
                fl_adq_o   = addr_q[DW-1:0];
                fl_addr_hi = addr_q[ADDR_W-1:DW];
            end
            ST_RGAP: begin
                fl_ce_n    = 1'b0;
                fl_addr_hi = addr_q[ADDR_W-1:DW];
            end
            ST_ROE: begin
                fl_ce_n    = 1'b0;
                fl_oe_n    = 1'b0;
                fl_addr_hi = addr_q[ADDR_W-1:DW];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/nor_flash_seq_chk.sv
module nor_flash_seq_chk #(
    parameter int ADDR_W = 22
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic                 op_done,
    input logic                 op_error,
    input logic                 fl_ce_n,
    input logic                 fl_we_n,
    input logic                 fl_oe_n,
    input logic                 fl_avd_n,
    input logic [ADDR_W-17:0]   fl_addr_hi,
    input logic                 fl_adq_oe
);
    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
        (req_ready && req_valid) |=> !req_ready);                         // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (fl_ce_n && fl_we_n && fl_oe_n && !fl_adq_oe));      // R1
    AST_AVD_SINGLE: assert property (@(posedge clk) disable iff (rst)
        !fl_avd_n |=> fl_avd_n);                                          // R5
    AST_WE_AFTER_ADDR: assert property (@(posedge clk) disable iff (rst)
        $fell(fl_we_n) |-> $past(!fl_avd_n));                             // R5
    AST_HI_STABLE_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
        !fl_we_n |-> $stable(fl_addr_hi));                                // R5
    AST_NO_WE_OE_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(!fl_we_n && !fl_oe_n));                                         // R5
    AST_BUS_RELEASED: assert property (@(posedge clk) disable iff (rst)
        !fl_oe_n |-> !fl_adq_oe);                                         // R6
    AST_GAP_BEFORE_OE: assert property (@(posedge clk) disable iff (rst)
        $fell(fl_oe_n) |-> $past(!fl_adq_oe));                            // R6
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        !(op_done && op_error));                                          // R9
    AST_OUTCOME_IDLE: assert property (@(posedge clk) disable iff (rst)
        (op_done || op_error) |-> req_ready);                             // R9
    AST_OUTCOME_PULSE: assert property (@(posedge clk) disable iff (rst)
        (op_done || op_error) |=> !(op_done || op_error));                // R9
endmodule

bind nor_flash_seq nor_flash_seq_chk #(.ADDR_W(ADDR_W)) u_seq_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .op_done    (op_done),
    .op_error   (op_error),
    .fl_ce_n    (fl_ce_n),
    .fl_we_n    (fl_we_n),
    .fl_oe_n    (fl_oe_n),
    .fl_avd_n   (fl_avd_n),
    .fl_addr_hi (fl_addr_hi),
    .fl_adq_oe  (fl_adq_oe)
);

// File: tb/nor_flash_seq_test.sv
module nor_flash_seq_test;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [1:0]  op;
        logic [21:0] addr;
        logic [15:0] data;
        logic [7:0]  lo;
        logic [7:0]  hi;
        logic [7:0]  busy;
        logic [15:0] lim;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [0:NV-1] = '{
        '{2'd0, 22'h0A1234, 16'hBEEF, 8'd3, 8'd2, 8'd3, 16'd10},
        '{2'd1, 22'h3F0000, 16'h0000, 8'd1, 8'd1, 8'd0, 16'd5},
        '{2'd2, 22'h000100, 16'h1111, 8'd2, 8'd4, 8'd5, 16'd8},
        '{2'd0, 22'h15ABCD, 16'h0000, 8'd0, 8'd0, 8'd1, 16'd1},
        '{2'd1, 22'h2A5555, 16'h2222, 8'd5, 8'd3, 8'd6, 16'd4},
        '{2'd0, 22'h000555, 16'hFFFF, 8'd2, 8'd1, 8'd2, 16'd0},
        '{2'd3, 22'h200002, 16'h5A5A, 8'd1, 8'd2, 8'd0, 16'd3}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [21:0] req_addr = '0;
    logic [15:0] req_data = '0;
    logic [7:0]  cfg_wr_low = 8'd1;
    logic [7:0]  cfg_wr_high = 8'd1;
    logic [15:0] cfg_poll_limit = 16'd4;
    logic        op_done, op_error;
    logic        fl_ce_n, fl_we_n, fl_oe_n, fl_avd_n, fl_adq_oe;
    logic [5:0]  fl_addr_hi;
    logic [15:0] fl_adq_o;
    logic [15:0] fl_adq_i;

    int n_checks = 0;
    int n_fail = 0;

    // flash model and bus monitor state
    logic        mon_clr = 1'b0;
    logic [21:0] cur_tgt = '0;
    int          busy_b = 0;
    logic [21:0] lat_addr;
    logic [21:0] wa [0:7];
    logic [15:0] wd [0:7];
    int          wl [0:7];
    int          nwr, nrd, lowrun, hi_total, bus_viol, rd_addr_bad, n_done, n_err;
    logic        we_prev, oe_prev, adq_oe_prev;
    logic        st6;

    always #(CLK_PERIOD/2) clk = ~clk;

    nor_flash_seq uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
        .cfg_wr_low(cfg_wr_low), .cfg_wr_high(cfg_wr_high),
        .cfg_poll_limit(cfg_poll_limit), .op_done(op_done), .op_error(op_error),
        .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n),
        .fl_avd_n(fl_avd_n), .fl_addr_hi(fl_addr_hi), .fl_adq_o(fl_adq_o),
        .fl_adq_oe(fl_adq_oe), .fl_adq_i(fl_adq_i)
    );

    // bit 6 flips on each of the first busy_b reads, then holds
    always_comb begin
        st6      = (nrd < busy_b) ? nrd[0] : busy_b[0];
        fl_adq_i = {9'h000, st6, 6'h01};
    end

    always @(negedge clk) begin
        if (rst || mon_clr) begin
            nwr <= 0; nrd <= 0; lowrun <= 0; hi_total <= 0;
            bus_viol <= 0; rd_addr_bad <= 0; n_done <= 0; n_err <= 0;
            we_prev <= 1'b1; oe_prev <= 1'b1; adq_oe_prev <= 1'b0;
            lat_addr <= '0;
        end else begin
            if (!fl_avd_n) lat_addr <= {fl_addr_hi, fl_adq_o};
            if (!fl_we_n) lowrun <= lowrun + 1;
            if (!we_prev && fl_we_n) begin
                if (nwr < 8) begin
                    wa[nwr] <= lat_addr;
                    wd[nwr] <= fl_adq_o;
                    wl[nwr] <= lowrun;
                end
                nwr    <= nwr + 1;
                lowrun <= 0;
            end
            if (!fl_ce_n && fl_we_n && fl_oe_n && fl_avd_n && fl_adq_oe)
                hi_total <= hi_total + 1;
            if (!fl_oe_n && fl_adq_oe) bus_viol <= bus_viol + 1;
            if (!fl_oe_n && oe_prev) begin
                if (lat_addr != cur_tgt) rd_addr_bad <= rd_addr_bad + 1;
                if (adq_oe_prev) bus_viol <= bus_viol + 1;
            end
            if (!oe_prev && fl_oe_n) nrd <= nrd + 1;
            if (op_done)  n_done <= n_done + 1;
            if (op_error) n_err  <= n_err + 1;
            we_prev     <= fl_we_n;
            oe_prev     <= fl_oe_n;
            adq_oe_prev <= fl_adq_oe;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    // expected {address, data} of write idx
    function automatic logic [37:0] exp_wr(logic [1:0] op, int idx, logic [21:0] a, logic [15:0] d);
        bit er;
        er = (op == 2'd1) || (op == 2'd2);
        case (idx)
            0: return {22'h000555, 16'h00AA};
            1: return {22'h0002AA, 16'h0055};
            2: return {22'h000555, er ? 16'h0080 : 16'h00A0};
            3: return er ? {22'h000555, 16'h00AA} : {a, d};
            4: return {22'h0002AA, 16'h0055};
            default: return (op == 2'd2) ? {22'h000555, 16'h0010} : {a, 16'h0030};
        endcase
    endfunction

    task automatic idle_outputs(input string req);
        check(req_ready === 1'b1, req, req_ready, 1);
        check({fl_ce_n, fl_we_n, fl_oe_n, fl_avd_n, fl_adq_oe} === 5'b11110,
              req, {fl_ce_n, fl_we_n, fl_oe_n, fl_avd_n, fl_adq_oe}, 5'b11110);
    endtask

    task automatic run_vec(input vec_t v, input bit hold_busy);
        int nw, lo_e, hi_e, lim_e, rd_e, w;
        bit err_e;
        string rq;
        nw    = (v.op == 2'd1 || v.op == 2'd2) ? 6 : 4;
        rq    = (v.op == 2'd1) ? "R3" : (v.op == 2'd2) ? "R4" : "R2";
        lo_e  = (v.lo == 0) ? 1 : int'(v.lo);
        hi_e  = (v.hi == 0) ? 1 : int'(v.hi);
        lim_e = (v.lim == 0) ? 1 : int'(v.lim);
        err_e = int'(v.busy) >= lim_e;
        rd_e  = err_e ? lim_e + 1 : int'(v.busy) + 2;

        mon_clr = 1'b1;
        cur_tgt = v.addr;
        busy_b  = int'(v.busy);
        cfg_wr_low = v.lo; cfg_wr_high = v.hi; cfg_poll_limit = v.lim;
        @(negedge clk); #1 mon_clr = 1'b0;
        req_valid = 1'b1; req_op = v.op; req_addr = v.addr; req_data = v.data;
        @(negedge clk);
        check(req_ready === 1'b0, "R1", req_ready, 0);
        if (hold_busy) begin
            req_op = 2'd2; req_addr = 22'h3FFFFF; req_data = 16'h0BAD;
            repeat (10) @(negedge clk);
        end
        req_valid = 1'b0;
        w = 0;
        while (!(op_done || op_error) && w < 20000) begin
            @(negedge clk);
            w++;
        end
        check(req_ready === 1'b1, "R9", req_ready, 1);
        repeat (4) @(negedge clk);
        check(fl_ce_n === 1'b1, "R9", fl_ce_n, 1);
        check(n_done + n_err == 1, "R9", n_done + n_err, 1);
        check(n_err == int'(err_e), err_e ? "R8" : "R7", n_err, err_e);
        check(nwr == nw, rq, nwr, nw);
        for (int i = 0; i < nw && i < 8; i++) begin
            check({wa[i], wd[i]} == exp_wr(v.op, i, v.addr, v.data), rq,
                  {wa[i], wd[i]}, exp_wr(v.op, i, v.addr, v.data));
            check(wl[i] == lo_e, "R5", wl[i], lo_e);
        end
        check(hi_total == nw * hi_e, "R5", hi_total, nw * hi_e);
        check(nrd == rd_e, err_e ? "R8" : "R7", nrd, rd_e);
        check(rd_addr_bad == 0, "R7", rd_addr_bad, 0);
        check(bus_viol == 0, "R6", bus_viol, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        idle_outputs("R1");
        check(op_done === 1'b0 && op_error === 1'b0, "R1", {op_done, op_error}, 0);
        #1 rst = 1'b0;
        @(negedge clk);
        idle_outputs("R1");

        for (int k = 0; k < NV; k++) run_vec(VECS[k], 1'b0);

        // second request held valid while busy must not start anything
        run_vec('{2'd0, 22'h012345, 16'hC0DE, 8'd4, 8'd3, 8'd2, 16'd6}, 1'b1);

        // reset in the middle of a write returns the bus to idle
        cfg_wr_low = 8'd6; cfg_wr_high = 8'd2; cfg_poll_limit = 16'd3;
        req_valid = 1'b1; req_op = 2'd1; req_addr = 22'h010000;
        @(negedge clk); req_valid = 1'b0;
        repeat (4) @(negedge clk);
        check(fl_we_n === 1'b0, "R5", fl_we_n, 0);
        rst = 1'b1;
        @(negedge clk);
        idle_outputs("R1");
        rst = 1'b0;
        repeat (3) @(negedge clk);
        idle_outputs("R1");

        summary();
        $finish;
    end
endmodule